// File: doc/BRIEF.md
# Saturating Two-Digit Ticket Counter

This block keeps a two-digit decimal queue number for a customer-facing display. Each clock edge on which the advance input is high moves the number up by one. The ones and tens digits are held as separate BCD registers. When the ones digit rolls over from 9 to 0, the tens digit moves up by one. The count does not wrap at 99. It stops at 80 and stays there until a clear or a reset brings it back to 00.

Each digit is also decoded into a 7-segment pattern, so a pair of displays can be wired straight to the outputs. The raw BCD digits and a flag that shows the saturated state are brought out as well. Everything is synchronous to one clock. The count source is assumed to be a one-cycle enable, so the digits only ever show legal decimal values.

Top module: `ticket_counter`

## Requirements
- R1: When rst_n is sampled low on a rising edge, both digits become 0. Reset takes priority over clear and advance.
- R2: On a rising edge where rst_n and clr are high and adv is low, the count keeps its value.
- R3: When adv is high on a rising edge, clr is low and the count is below 80, the decimal value tens*10+ones goes up by exactly one.
- R4: The ones digit stays within 0..9. An advance taken at ones = 9 sets ones to 0 and adds one to tens in the same edge.
- R5: The tens digit never goes above 8. While the count is 80, an advance is ignored and the count stays at 80.
- R6: When clr is high on a rising edge and rst_n is high, both digits become 0 from any value, 80 included. Clear takes priority over adv.
- R7: Each 7-segment bus is active-high, with bit 0 = segment a through bit 6 = segment g. The patterns as hex are 0:3F, 1:06, 2:5B, 3:4F, 4:66, 5:6D, 6:7D, 7:07, 8:7F, 9:6F. A BCD code above 9 gives 00.
- R8: at_max is high exactly when the count is 80, that is, when tens = 8 and ones = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| clr | input | 1 | Synchronous clear to 00 |
| adv | input | 1 | Advance enable, one step per edge |
| ones_bcd | output | 4 | Ones digit as BCD |
| tens_bcd | output | 4 | Tens digit as BCD |
| ones_seg | output | 7 | Ones digit segments, bit 0 = a |
| tens_seg | output | 7 | Tens digit segments, bit 0 = a |
| at_max | output | 1 | High while the count holds at 80 |

## Verification
The assertions check on every cycle that each digit stays in its legal range and that the tens digit never wraps. They also check that a clear lands on 00, that an idle edge keeps the value, that a step below the limit adds exactly one to the decimal value, and that the count does not move while it is at 80. Only the bench's scenarios can show the exact 7-segment patterns, when the saturation flag rises and falls, reset arriving in the middle of a count, and a clear and an advance arriving on the same edge. The bench compares these against a reference count that it keeps itself, cycle by cycle.

// File: rtl/tc_pkg.sv
// Package: shared widths, digit and segment types, and the BCD to
// 7-segment mapping used by the ticket counter.
// Assumes segment bit 0 is segment a and bit 6 is segment g, active high.
package tc_pkg;

    localparam int unsigned BCD_W = 4;
    localparam int unsigned SEG_W = 7;

    typedef logic [BCD_W-1:0] bcd_t;
    typedef logic [SEG_W-1:0] seg_t;

    // Map one BCD code to its glyph; codes above nine blank the digit.
    function automatic seg_t bcd_to_seg(input bcd_t code);
        seg_t pat;
        unique case (code)
            4'd0:    pat = 7'h3F;
            4'd1:    pat = 7'h06;
            4'd2:    pat = 7'h5B;
            4'd3:    pat = 7'h4F;
            4'd4:    pat = 7'h66;
            4'd5:    pat = 7'h6D;
            4'd6:    pat = 7'h7D;
            4'd7:    pat = 7'h07;
            4'd8:    pat = 7'h7F;
            4'd9:    pat = 7'h6F;
            default: pat = '0;
        endcase
        return pat;
    endfunction

endpackage

// File: rtl/tc_digit.sv
// Module: tc_digit
// One decimal digit register. It steps up by one when step_i is high and
// returns to zero after TOP, raising roll_o in the cycle that wraps.
// Assumes step_i is a one-cycle enable and clr_i is synchronous.
module tc_digit
    import tc_pkg::*;
#(
    parameter int unsigned TOP = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic step_i,
    output bcd_t val_o,
    output logic roll_o
);

    localparam bcd_t TOP_V = bcd_t'(TOP);

    bcd_t val_q;

    // Wrap indication: a step taken while sitting at the top value.
    assign roll_o = step_i && (val_q == TOP_V);
    assign val_o  = val_q;

    // Digit register: reset, then clear, then step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val_q <= '0;
        end else if (clr_i) begin
            val_q <= '0;
        end else if (step_i) begin
            val_q <= (val_q == TOP_V) ? '0 : val_q + 1'b1;
        end
    end

    // R4: digit never leaves 0..TOP
    assert_digit_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        val_q <= TOP_V);

    // R4: a wrap lands on zero in the next cycle
    assert_digit_wrap_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (roll_o && !clr_i) |=> (val_q == '0));

endmodule

// File: rtl/tc_seg_encoder.sv
// Module: tc_seg_encoder
// Turns one BCD digit into an active-high 7-segment pattern.
// Assumes bit 0 is segment a; codes above nine blank the display.
module tc_seg_encoder
    import tc_pkg::*;
(
    input  bcd_t digit_i,
    output seg_t seg_o
);

    // Pure lookup: glyph for the present digit.
    always_comb begin
        seg_o = bcd_to_seg(digit_i);
    end

endmodule

// File: rtl/ticket_counter.sv
// Module: ticket_counter
// Two-digit decimal counter that saturates at LIMIT_TENS*10+LIMIT_ONES
// (80 by default), with synchronous clear and per-digit 7-segment outputs.
// Assumes adv is a one-cycle enable sampled on the rising edge and that
// clear beats advance; reset (active low, synchronous) beats both.
module ticket_counter
    import tc_pkg::*;
#(
    parameter int unsigned LIMIT_TENS = 8,
    parameter int unsigned LIMIT_ONES = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             adv,
    output logic [BCD_W-1:0] ones_bcd,
    output logic [BCD_W-1:0] tens_bcd,
    output logic [SEG_W-1:0] ones_seg,
    output logic [SEG_W-1:0] tens_seg,
    output logic             at_max
);

    localparam int unsigned NUM_DIG = 2;
    localparam bcd_t        LIM_T   = bcd_t'(LIMIT_TENS);
    localparam bcd_t        LIM_O   = bcd_t'(LIMIT_ONES);
    localparam int unsigned VAL_W   = 8;

    bcd_t       dig   [NUM_DIG];
    seg_t       seg   [NUM_DIG];
    logic       roll  [NUM_DIG];
    logic       step  [NUM_DIG];
    logic       sat;
    logic [VAL_W-1:0] value;

    // Saturation detect: count sits on the limit value.
    assign sat = (dig[1] == LIM_T) && (dig[0] == LIM_O);

    // Step chain: ones takes advances below the limit, tens takes the wrap.
    always_comb begin
        step[0] = adv && !sat;
        step[1] = roll[0];
    end

    tc_digit #(.TOP(9)) u_ones (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .step_i (step[0]),
        .val_o  (dig[0]),
        .roll_o (roll[0])
    );

    tc_digit #(.TOP(9)) u_tens (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr),
        .step_i (step[1]),
        .val_o  (dig[1]),
        .roll_o (roll[1])
    );

    // One glyph encoder per digit.
    for (genvar g = 0; g < NUM_DIG; g++) begin : g_enc
        tc_seg_encoder u_enc (
            .digit_i (dig[g]),
            .seg_o   (seg[g])
        );
    end

    // Decimal value of the count, used by the checks below.
    assign value = (VAL_W'(dig[1]) * VAL_W'(10)) + VAL_W'(dig[0]);

    assign ones_bcd = dig[0];
    assign tens_bcd = dig[1];
    assign ones_seg = seg[0];
    assign tens_seg = seg[1];
    assign at_max   = sat;

    // R1: a sampled reset yields 00
    assert_reset_zero_R1: assert property (@(posedge clk)
        !rst_n |=> (value == '0));

    // R2: idle edge keeps the count
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !adv) |=> $stable(value));

    // R3: an accepted advance adds exactly one
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && adv && !sat) |=> (value == $past(value) + VAL_W'(1)));

    // R5: tens digit capped and never wraps
    assert_tens_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dig[1] <= LIM_T) && !roll[1]);

    // R5: advances at the limit are ignored
    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (sat && !clr) |=> (value == $past(value)));

    // R6: clear lands on 00 whatever else is asserted
    assert_clear_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (value == '0));

endmodule

// File: tb/ticket_counter_tb.sv
// Scoreboard bench: the driver applies one edge of stimulus, advances a
// reference count and queues the expected outputs; the monitor pops and
// compares a quarter period after each rising edge.
module ticket_counter_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr = 1'b0;
    logic       adv = 1'b0;
    logic [3:0] ones_bcd, tens_bcd;
    logic [6:0] ones_seg, tens_seg;
    logic       at_max;

    int n_checks = 0;
    int n_errors = 0;
    int ref_count = 0;
    bit done = 1'b0;

    logic [8:0] exp_q[$];   // {at_max, tens, ones}
    string      tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    ticket_counter u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (clr),
        .adv      (adv),
        .ones_bcd (ones_bcd),
        .tens_bcd (tens_bcd),
        .ones_seg (ones_seg),
        .tens_seg (tens_seg),
        .at_max   (at_max)
    );

    // R7 reference glyphs, bit 0 = segment a
    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'b0111111;
            1: return 7'b0000110;
            2: return 7'b1011011;
            3: return 7'b1001111;
            4: return 7'b1100110;
            5: return 7'b1101101;
            6: return 7'b1111101;
            7: return 7'b0000111;
            8: return 7'b1111111;
            9: return 7'b1101111;
            default: return 7'b0000000;
        endcase
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: one clock of stimulus plus the expected result.
    task automatic drive(input bit r_n, input bit c, input bit a, input string tag);
        @(negedge clk);
        rst_n = r_n;
        clr   = c;
        adv   = a;
        if (!r_n)          ref_count = 0;
        else if (c)        ref_count = 0;
        else if (a && ref_count < 80) ref_count++;
        exp_q.push_back({(ref_count == 80), 4'(ref_count / 10), 4'(ref_count % 10)});
        tag_q.push_back(tag);
    endtask

    // Monitor: compare outputs after each edge against the queue.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (exp_q.size() > 0) begin
                logic [8:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check({t, " value"}, int'(tens_bcd) * 10 + int'(ones_bcd),
                      int'(e[7:4]) * 10 + int'(e[3:0]));
                check("R7 ones glyph", int'(ones_seg), int'(glyph(int'(e[3:0]))));
                check("R7 tens glyph", int'(tens_seg), int'(glyph(int'(e[7:4]))));
                check("R8 at_max", int'(at_max), int'(e[8]));
            end
        end
    end

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        drive(1'b0, 1'b0, 1'b0, "R1 reset");
        drive(1'b0, 1'b1, 1'b1, "R1 reset beats clear/advance");
        // R3/R4: count up through a ones wrap
        for (int i = 0; i < 12; i++) drive(1'b1, 1'b0, 1'b1, "R3 step");
        // R2: idle edges hold
        for (int i = 0; i < 4; i++) drive(1'b1, 1'b0, 1'b0, "R2 idle");
        // R3: sparse advances
        for (int i = 0; i < 10; i++) drive(1'b1, 1'b0, (i % 3) == 0, "R3 sparse");
        // R6: clear beats advance mid-count
        drive(1'b1, 1'b1, 1'b1, "R6 clear with advance");
        // R4/R5: run to the limit and beyond
        for (int i = 0; i < 90; i++) drive(1'b1, 1'b0, 1'b1, "R5 run to 80");
        for (int i = 0; i < 3; i++) drive(1'b1, 1'b0, 1'b0, "R5 idle at 80");
        // R6: clear from the held value
        drive(1'b1, 1'b1, 1'b0, "R6 clear from 80");
        for (int i = 0; i < 19; i++) drive(1'b1, 1'b0, 1'b1, "R4 carry to 19");
        drive(1'b1, 1'b0, 1'b1, "R4 wrap 19->20");
        // R1: reset in mid count
        drive(1'b0, 1'b0, 1'b1, "R1 mid-count reset");
        drive(1'b1, 1'b0, 1'b1, "R3 after reset");
        drive(1'b1, 1'b0, 1'b0, "R2 final idle");
        repeat (3) @(posedge clk);
        #(CLK_PERIOD/2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule